// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits between a video decoder's 4:2:2 sample stream and a graphics controller. Each incoming sample pair (one luma byte, one chroma byte) is put onto two byte-wide output ports with an active-video flag and a pixel qualifier strobe. Everything runs on one line-locked clock. The qualifier is a registered enable that the receiver samples on the same clock, not a derived clock.

There are three timing modes. Single rate sends one pair per clock, with luma on port A and chroma on port B. Double rate sends chroma and then luma on port A over two clocks. Half rate holds each pair on both ports for two clocks and gates every second qualifier pulse. To make room for this, a half-rate line is written into a line buffer at the input rate and read out at half that rate. The buffer has a fixed maximum line length, and samples beyond that length are dropped.

The mode is chosen by configuration inputs. It is latched only when a new line starts. Half rate is granted only when the studio (601-style) output format is also selected. Otherwise the block runs at single rate and records a sticky configuration error.

Top module: `pix_out_fmt`

## Requirements
- R1: After reset, and whenever `vact` is low, `port_a` carries 0x10 and `port_b` carries 0x80. After reset `pix_qual` is high and both sticky flags are low.
- R2: Single rate is the mode when `cfg_ctrl` bit 0 and bit 5 are both 0. A pair accepted at a clock edge (`in_active` and `in_valid` high) appears one clock later with luma on `port_a`, chroma on `port_b` and `vact` high. `pix_qual` is high on every clock, including blanking.
- R3: Double rate is the mode when `cfg_ctrl` bit 0 is 1 and bit 5 is 0. A pair accepted at edge E puts its chroma on `port_a` after E and its luma on `port_a` after E+1. `vact` is high for both clocks, `port_b` stays 0x80, and `pix_qual` is high on every clock.
- R4: Half rate is the mode when `cfg_ctrl` bit 5 is 1 and `cfg_fmt601` is 1. The k-th pair of a line (k from 0) is shown with luma on `port_a` and chroma on `port_b` for the two clocks after edges S+2k+1 and S+2k+2, where S is the line-start edge. `vact` stays high from the first pair through the last pair.
- R5: In half rate, `pix_qual` is low after the line-start edge. After that it is high after every odd-numbered edge and low after every even-numbered one, so two adjacent clocks never both carry a pulse.
- R6: If bit 5 is set while `cfg_fmt601` is 0, the line runs exactly as in single rate, and `cfg_error` goes high at that line's start.
- R7: In half rate, a line that carries more than LINE_MAX pairs sets `line_overflow`. Only the first LINE_MAX pairs are output and the excess is dropped.
- R8: A change of `cfg_ctrl` or `cfg_fmt601` during a line has no effect until the next rising edge of `in_active`.
- R9: When bit 5 and bit 0 are both set and `cfg_fmt601` is 1, half rate takes precedence.
- R10: `cfg_error` and `line_overflow` stay high once set and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_active | input | 1 | Input active-line flag; its rising edge starts a line |
| in_valid | input | 1 | Input sample pair present this clock |
| in_luma | input | DATA_W | Luma sample |
| in_chroma | input | DATA_W | Chroma sample |
| cfg_ctrl | input | CTRL_W | Control byte: bit 0 selects double rate, bit 5 requests half rate |
| cfg_fmt601 | input | 1 | Studio 601-style output format selected |
| port_a | output | DATA_W | Output port A |
| port_b | output | DATA_W | Output port B |
| vact | output | 1 | Active output samples present |
| pix_qual | output | 1 | Pixel qualifier strobe |
| cfg_error | output | 1 | Sticky: half rate requested without the 601 format |
| line_overflow | output | 1 | Sticky: half-rate line exceeded LINE_MAX pairs |

## Verification
The assertions assume the following about the inputs. In double rate, pairs arrive no more often than every second clock. In half rate, pair k of a line arrives no later than k*2 clocks after the line start, so the buffer never runs dry while draining. The gap between lines is long enough for the buffer to empty before the next rising edge of `in_active`. The stimulus respects all three conditions: double-rate lines present a pair only on even cycles of the line, half-rate lines present a pair on every cycle, and every line is followed by enough idle cycles to drain the buffer before the next line begins.

// File: rtl/pof_pkg.sv
package pof_pkg;

   typedef enum logic [1:0] {
      POF_SINGLE = 2'd0,
      POF_DOUBLE = 2'd1,
      POF_HALF   = 2'd2
   } pof_mode_e;

endpackage

// File: rtl/pof_mode_ctl.sv
module pof_mode_ctl
   import pof_pkg::*;
#(
   parameter int CTRL_W   = 8,
   parameter int HALF_BIT = 5,
   parameter int DBL_BIT  = 0,
   parameter bit HALF_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_active,
   input  logic [CTRL_W-1:0] cfg_ctrl,
   input  logic              cfg_fmt601,
   output logic              line_start,
   output pof_mode_e         mode_now,
   output pof_mode_e         mode_q,
   output logic              cfg_error
);

   logic      act_q;
   logic      half_req;
   logic      fmt_ok;
   logic      bad_cfg;
   pof_mode_e req_mode;

   // Only the selector bits matter; the rest of the control byte is not decoded here.
   logic unused_ctrl;
   assign unused_ctrl = ^cfg_ctrl;

   generate
      if (HALF_EN) begin : g_half
         assign half_req = cfg_ctrl[HALF_BIT];
         assign fmt_ok   = cfg_fmt601;
      end else begin : g_nohalf
         logic unused_fmt;
         assign unused_fmt = cfg_fmt601;
         assign half_req   = 1'b0;
         assign fmt_ok     = 1'b0;
      end
   endgenerate

   assign line_start = in_active & ~act_q;
   assign bad_cfg    = half_req & ~fmt_ok;

   always_comb begin
      if (half_req && fmt_ok)    req_mode = POF_HALF;
      else if (half_req)         req_mode = POF_SINGLE;
      else if (cfg_ctrl[DBL_BIT]) req_mode = POF_DOUBLE;
      else                       req_mode = POF_SINGLE;
   end

   assign mode_now = line_start ? req_mode : mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         mode_q    <= POF_SINGLE;
         cfg_error <= 1'b0;
      end else begin
         act_q <= in_active;
         if (line_start) begin
            mode_q <= req_mode;
            if (bad_cfg) cfg_error <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pof_line_buf.sv
module pof_line_buf #(
   parameter int DATA_W   = 8,
   parameter int LINE_MAX = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_luma,
   input  logic [DATA_W-1:0] wr_chroma,
   input  logic              rd_en,
   output logic              rd_avail,
   output logic [DATA_W-1:0] rd_luma,
   output logic [DATA_W-1:0] rd_chroma,
   output logic              overflow
);

   localparam int ADDR_W = $clog2(LINE_MAX);
   localparam int CNT_W  = $clog2(LINE_MAX + 1);
   localparam int PAIR_W = 2 * DATA_W;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LINE_MAX);

   logic [PAIR_W-1:0] mem [LINE_MAX];
   logic [CNT_W-1:0]  wr_cnt, rd_cnt;
   logic [CNT_W-1:0]  wr_base;
   logic              full;
   logic              do_wr;
   logic [PAIR_W-1:0] rd_word;

   assign wr_base = clear ? '0 : wr_cnt;
   assign full    = (wr_base == FULL_CNT);
   assign do_wr   = wr_en & ~full;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_base[ADDR_W-1:0]] <= {wr_luma, wr_chroma};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt   <= '0;
         rd_cnt   <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_wr)       wr_cnt <= wr_base + 1'b1;
         else if (clear)  wr_cnt <= '0;
         if (clear)       rd_cnt <= '0;
         else if (rd_en)  rd_cnt <= rd_cnt + 1'b1;
         if (wr_en && full) overflow <= 1'b1;
      end
   end

   assign rd_avail  = (rd_cnt < wr_cnt);
   assign rd_word   = mem[rd_cnt[ADDR_W-1:0]];
   assign rd_luma   = rd_word[PAIR_W-1:DATA_W];
   assign rd_chroma = rd_word[DATA_W-1:0];

endmodule

// File: rtl/pof_out_stage.sv
module pof_out_stage
   import pof_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] BLANK_Y = 'h10,
   parameter logic [DATA_W-1:0] BLANK_C = 'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pof_mode_e         mode_now,
   input  logic              line_start,
   input  logic              in_take,
   input  logic [DATA_W-1:0] in_luma,
   input  logic [DATA_W-1:0] in_chroma,
   input  logic              buf_avail,
   input  logic [DATA_W-1:0] buf_luma,
   input  logic [DATA_W-1:0] buf_chroma,
   output logic              buf_pop,
   output logic [DATA_W-1:0] port_a,
   output logic [DATA_W-1:0] port_b,
   output logic              vact,
   output logic              pix_qual
);

   logic              phase;    // half rate: 0 = pulse slot, 1 = gated slot
   logic              dbl_pend; // double rate: luma still owed
   logic [DATA_W-1:0] y_hold;

   assign buf_pop = (mode_now == POF_HALF) && !line_start && !phase && buf_avail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_a   <= BLANK_Y;
         port_b   <= BLANK_C;
         vact     <= 1'b0;
         pix_qual <= 1'b1;
         phase    <= 1'b0;
         dbl_pend <= 1'b0;
         y_hold   <= BLANK_Y;
      end else begin
         unique case (mode_now)
            POF_HALF: begin
               dbl_pend <= 1'b0;
               if (line_start) begin
                  port_a   <= BLANK_Y;
                  port_b   <= BLANK_C;
                  vact     <= 1'b0;
                  pix_qual <= 1'b0;
                  phase    <= 1'b0;
               end else if (!phase) begin
                  phase    <= 1'b1;
                  pix_qual <= 1'b1;
                  if (buf_avail) begin
                     port_a <= buf_luma;
                     port_b <= buf_chroma;
                     vact   <= 1'b1;
                  end else begin
                     port_a <= BLANK_Y;
                     port_b <= BLANK_C;
                     vact   <= 1'b0;
                  end
               end else begin
                  phase    <= 1'b0;
                  pix_qual <= 1'b0;
               end
            end
            POF_DOUBLE: begin
               phase    <= 1'b0;
               pix_qual <= 1'b1;
               port_b   <= BLANK_C;
               if (dbl_pend) begin
                  port_a   <= y_hold;
                  vact     <= 1'b1;
                  dbl_pend <= 1'b0;
               end else if (in_take) begin
                  port_a   <= in_chroma;
                  y_hold   <= in_luma;
                  vact     <= 1'b1;
                  dbl_pend <= 1'b1;
               end else begin
                  port_a <= BLANK_Y;
                  vact   <= 1'b0;
               end
            end
            default: begin
               phase    <= 1'b0;
               pix_qual <= 1'b1;
               dbl_pend <= 1'b0;
               if (in_take) begin
                  port_a <= in_luma;
                  port_b <= in_chroma;
                  vact   <= 1'b1;
               end else begin
                  port_a <= BLANK_Y;
                  port_b <= BLANK_C;
                  vact   <= 1'b0;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
   import pof_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                CTRL_W   = 8,
   parameter int                HALF_BIT = 5,
   parameter int                DBL_BIT  = 0,
   parameter int                LINE_MAX = 400,
   parameter bit                HALF_EN  = 1'b1,
   parameter logic [DATA_W-1:0] BLANK_Y  = 'h10,
   parameter logic [DATA_W-1:0] BLANK_C  = 'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_active,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_luma,
   input  logic [DATA_W-1:0] in_chroma,
   input  logic [CTRL_W-1:0] cfg_ctrl,
   input  logic              cfg_fmt601,
   output logic [DATA_W-1:0] port_a,
   output logic [DATA_W-1:0] port_b,
   output logic              vact,
   output logic              pix_qual,
   output logic              cfg_error,
   output logic              line_overflow
);

   initial begin
      if (LINE_MAX < 2)        $error("pix_out_fmt: LINE_MAX must be at least 2");
      if (HALF_BIT >= CTRL_W)  $error("pix_out_fmt: HALF_BIT outside control word");
      if (DBL_BIT >= CTRL_W)   $error("pix_out_fmt: DBL_BIT outside control word");
      if (HALF_BIT == DBL_BIT) $error("pix_out_fmt: selector bits must differ");
      if (DATA_W < 1)          $error("pix_out_fmt: DATA_W must be positive");
   end

   logic              line_start;
   pof_mode_e         mode_now;
   pof_mode_e         mode_q;
   logic              take;
   logic              buf_wr;
   logic              buf_pop;
   logic              buf_avail;
   logic [DATA_W-1:0] buf_luma;
   logic [DATA_W-1:0] buf_chroma;

   assign take   = in_active & in_valid;
   assign buf_wr = take && (mode_now == POF_HALF);

   pof_mode_ctl #(
      .CTRL_W   (CTRL_W),
      .HALF_BIT (HALF_BIT),
      .DBL_BIT  (DBL_BIT),
      .HALF_EN  (HALF_EN)
   ) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_active  (in_active),
      .cfg_ctrl   (cfg_ctrl),
      .cfg_fmt601 (cfg_fmt601),
      .line_start (line_start),
      .mode_now   (mode_now),
      .mode_q     (mode_q),
      .cfg_error  (cfg_error)
   );

   generate
      if (HALF_EN) begin : g_buf
         pof_line_buf #(
            .DATA_W   (DATA_W),
            .LINE_MAX (LINE_MAX)
         ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (line_start),
            .wr_en     (buf_wr),
            .wr_luma   (in_luma),
            .wr_chroma (in_chroma),
            .rd_en     (buf_pop),
            .rd_avail  (buf_avail),
            .rd_luma   (buf_luma),
            .rd_chroma (buf_chroma),
            .overflow  (line_overflow)
         );
      end else begin : g_nobuf
         logic unused_buf;
         assign unused_buf    = buf_wr ^ buf_pop;
         assign buf_avail     = 1'b0;
         assign buf_luma      = BLANK_Y;
         assign buf_chroma    = BLANK_C;
         assign line_overflow = 1'b0;
      end
   endgenerate

   pof_out_stage #(
      .DATA_W  (DATA_W),
      .BLANK_Y (BLANK_Y),
      .BLANK_C (BLANK_C)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_now   (mode_now),
      .line_start (line_start),
      .in_take    (take),
      .in_luma    (in_luma),
      .in_chroma  (in_chroma),
      .buf_avail  (buf_avail),
      .buf_luma   (buf_luma),
      .buf_chroma (buf_chroma),
      .buf_pop    (buf_pop),
      .port_a     (port_a),
      .port_b     (port_b),
      .vact       (vact),
      .pix_qual   (pix_qual)
   );

endmodule

// File: rtl/pof_checker.sv
module pof_checker
   import pof_pkg::*;
#(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] BLANK_Y = 'h10,
   parameter logic [DATA_W-1:0] BLANK_C = 'h80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_active,
   input logic [DATA_W-1:0] port_a,
   input logic [DATA_W-1:0] port_b,
   input logic              vact,
   input logic              pix_qual,
   input logic              cfg_error,
   input logic              line_overflow,
   input pof_mode_e         mode_q
);

   AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !vact |-> (port_a == BLANK_Y && port_b == BLANK_C)); // R1

   AST_QUAL_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != POF_HALF) |-> pix_qual); // R2

   AST_DOUBLE_PORTB: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == POF_DOUBLE) |-> (port_b == BLANK_C)); // R3

   AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == POF_HALF && $past(mode_q) == POF_HALF && vact && !pix_qual)
      |-> ($stable(port_a) && $stable(port_b))); // R4

   AST_HALF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == POF_HALF && pix_qual) |=> (mode_q != POF_HALF || !pix_qual)); // R5

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      line_overflow |=> line_overflow); // R7

   AST_MODE_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_active && $past(in_active) && $past(in_active, 2)) |-> $stable(mode_q)); // R8

   AST_CFG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error); // R10

endmodule

bind pix_out_fmt pof_checker #(
   .DATA_W  (DATA_W),
   .BLANK_Y (BLANK_Y),
   .BLANK_C (BLANK_C)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_active     (in_active),
   .port_a        (port_a),
   .port_b        (port_b),
   .vact          (vact),
   .pix_qual      (pix_qual),
   .cfg_error     (cfg_error),
   .line_overflow (line_overflow),
   .mode_q        (mode_q)
);

// File: tb/tb_pix_out_fmt.sv
module tb_pix_out_fmt;

   localparam int LMAX = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_active, in_valid;
   logic [7:0] in_luma, in_chroma;
   logic [7:0] cfg_ctrl;
   logic       cfg_fmt601;
   logic [7:0] port_a, port_b;
   logic       vact, pix_qual, cfg_error, line_overflow;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #5 clk = ~clk;

   pix_out_fmt #(.LINE_MAX(LMAX)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_active     (in_active),
      .in_valid      (in_valid),
      .in_luma       (in_luma),
      .in_chroma     (in_chroma),
      .cfg_ctrl      (cfg_ctrl),
      .cfg_fmt601    (cfg_fmt601),
      .port_a        (port_a),
      .port_b        (port_b),
      .vact          (vact),
      .pix_qual      (pix_qual),
      .cfg_error     (cfg_error),
      .line_overflow (line_overflow)
   );

   function automatic logic [7:0] yv(int k);
      return 8'(32 + 3 * k);
   endfunction

   function automatic logic [7:0] cv(int k);
      return 8'(144 ^ k);
   endfunction

   task automatic check_out(string req, int j, logic [7:0] ea, logic [7:0] eb,
                            logic ev, logic eq);
      n_chk++;
      if (port_a !== ea || port_b !== eb || vact !== ev || pix_qual !== eq) begin
         n_fail++;
         $display("FAIL %s step %0d: a=%h b=%h vact=%b qual=%b expected a=%h b=%h vact=%b qual=%b",
                  req, j, port_a, port_b, vact, pix_qual, ea, eb, ev, eq);
      end
   endtask

   task automatic check_flag(string req, string name, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, name, act, exp);
      end
   endtask

   // md: 0 single, 1 double, 2 half (expected behaviour)
   task automatic run_line(int md, int n, logic [7:0] ctrl, logic fmt,
                           logic [7:0] ctrl_mid, string req);
      int act_len = (md == 1) ? 2 * n : n;
      int nout    = (md == 2 && n > LMAX) ? LMAX : n;
      int last    = (md == 2) ? 2 * nout + 3 : act_len + 2;
      for (int c = 0; c <= last + 1; c++) begin
         @(negedge clk);
         if (c >= 1) begin
            int j = c - 1;
            logic [7:0] ea = 8'h10;
            logic [7:0] eb = 8'h80;
            logic       ev = 1'b0;
            logic       eq = 1'b1;
            if (md == 0) begin
               if (j < n) begin ea = yv(j); eb = cv(j); ev = 1'b1; end
            end else if (md == 1) begin
               if (j < 2 * n) begin
                  ea = (j % 2 == 0) ? cv(j / 2) : yv(j / 2);
                  ev = 1'b1;
               end
            end else begin
               eq = (j % 2 == 1);
               if (j >= 1 && j <= 2 * nout) begin
                  ea = yv((j - 1) / 2); eb = cv((j - 1) / 2); ev = 1'b1;
               end
            end
            check_out(req, j, ea, eb, ev, eq);
         end
         if (c == 0) begin cfg_ctrl = ctrl; cfg_fmt601 = fmt; end
         if (c > 0 && c == act_len / 2) cfg_ctrl = ctrl_mid;
         in_active = (c < act_len);
         if (md == 1) begin
            in_valid  = (c < act_len) && (c % 2 == 0);
            in_luma   = yv(c / 2);
            in_chroma = cv(c / 2);
         end else begin
            in_valid  = (c < act_len);
            in_luma   = yv(c);
            in_chroma = cv(c);
         end
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      rst_n = 1'b0; in_active = 1'b0; in_valid = 1'b0;
      in_luma = 8'h00; in_chroma = 8'h00; cfg_ctrl = 8'h00; cfg_fmt601 = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_out("R1", -1, 8'h10, 8'h80, 1'b0, 1'b1);
      check_flag("R1", "cfg_error", cfg_error, 1'b0);
      check_flag("R1", "line_overflow", line_overflow, 1'b0);

      // Sweep of line lengths in each valid mode: R2 single, R3 double, R4/R5 half
      for (int n = 1; n <= 6; n++) begin
         run_line(0, n, 8'h00, 1'b1, 8'h00, "R2");
         run_line(1, n, 8'h01, 1'b1, 8'h01, "R3");
         run_line(2, n, 8'h20, 1'b1, 8'h20, "R4");
      end
      run_line(2, LMAX, 8'h20, 1'b1, 8'h20, "R5");

      // R9: half takes precedence over double
      run_line(2, 5, 8'h21, 1'b1, 8'h21, "R9");

      // R8: mid-line changes wait for the next line
      run_line(0, 6, 8'h00, 1'b1, 8'h01, "R8");
      run_line(1, 4, 8'h01, 1'b1, 8'h20, "R8");
      run_line(2, 4, 8'h20, 1'b1, 8'h00, "R8");
      run_line(0, 3, 8'h00, 1'b1, 8'h00, "R8");

      // R6: half requested without the 601 format falls back to single
      check_flag("R6", "cfg_error before", cfg_error, 1'b0);
      run_line(0, 4, 8'h20, 1'b0, 8'h20, "R6");
      check_flag("R6", "cfg_error after", cfg_error, 1'b1);
      run_line(1, 3, 8'h01, 1'b1, 8'h01, "R10");
      check_flag("R10", "cfg_error held", cfg_error, 1'b1);

      // R7: overlong half-rate line
      check_flag("R7", "overflow before", line_overflow, 1'b0);
      run_line(2, LMAX + 3, 8'h20, 1'b1, 8'h20, "R7");
      check_flag("R7", "overflow after", line_overflow, 1'b1);
      run_line(2, 3, 8'h20, 1'b1, 8'h20, "R7");
      check_flag("R10", "overflow held", line_overflow, 1'b1);

      // R10: reset clears the sticky flags
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_flag("R10", "cfg_error after reset", cfg_error, 1'b0);
      check_flag("R10", "overflow after reset", line_overflow, 1'b0);
      check_out("R1", -1, 8'h10, 8'h80, 1'b0, 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule